// File: doc/BRIEF.md
# Dual Ratio Clock Enable Generator with Deferred Switching

This block derives two clock enables from one external clock: a core enable for the fast domain (the DMA engine runs from this one) and a peripheral enable for every other peripheral. Each enable is produced by a power-of-two divider. A small control register holds one 3-bit ratio code for each domain.

Software writes the register at any time, but the new ratios are only held as pending. They take effect when the bus reports that its current cycle has finished. Both dividers then switch on that same edge, so the change lands within one external clock cycle. Both divider counters restart from zero when the switch happens, so neither enable produces a shortened period.

The core ratio always wins. If the programmed peripheral code would make the peripheral enable faster than the core enable, the peripheral divider uses the core code instead. Reads return the raw programmed codes. A status output reports the ratios in effect and whether a change is pending.

Top module: `clkdiv_ctrl`

## Requirements
- R1: After reset, rd_data is 0, eff_sys and eff_per are 0, pending is 0, and sys_ce and per_ce are high on every cycle.
- R2: A write with wr_en high stores wr_data[2:0] as the core code and wr_data[5:3] as the peripheral code. rd_data returns those raw codes in the same bit positions, even when a code is reserved or clamped.
- R3: A write sets pending in the next cycle. While a change is pending, eff_sys, eff_per and the enable pattern do not change.
- R4: When bus_cycle_done is high while pending is set and wr_en is low, the next cycle shows the new eff_sys and eff_per with pending cleared. When bus_cycle_done is high with nothing pending, nothing changes.
- R5: A write in the same cycle as bus_cycle_done takes precedence. The latest value is stored, pending stays set and no switch occurs. A later bus_cycle_done applies that latest value.
- R6: Codes 0, 1, 2, 3 and 4 divide by 1, 2, 4, 8 and 16. Reserved codes 5, 6 and 7 divide by 16 and are reported as 4 on eff_sys and eff_per.
- R7: The effective peripheral code is the larger of the normalised peripheral code and the normalised core code, so eff_per >= eff_sys always holds.
- R8: In the first cycle after a switch, both sys_ce and per_ce are high. After that, each repeats with a period of exactly its effective divide ratio.
- R9: per_ce is never high in a cycle where sys_ce is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | External clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 6 | Write data: [2:0] core code, [5:3] peripheral code |
| bus_cycle_done | input | 1 | One-cycle pulse: the current bus cycle has finished |
| rd_data | output | 6 | Programmed codes, same layout as wr_data |
| sys_ce | output | 1 | Core clock enable |
| per_ce | output | 1 | Peripheral clock enable |
| eff_sys | output | 3 | Core code in effect (0 to 4) |
| eff_per | output | 3 | Peripheral code in effect, after clamping (0 to 4) |
| pending | output | 1 | A written change is waiting for bus_cycle_done |

## Verification
The checker tests the following properties on every cycle:
- the clamp ordering of the effective codes, and their normalised range;
- that pending rises only after a write and clears after an accepted switch;
- that the effective codes hold still unless a switch is taken;
- that both enables fire right after a switch;
- that the peripheral enable never appears without the core enable.

Some properties need the bench's directed scenarios:
- the exact ratio chosen for each code, including the reserved ones;
- the period measured between enables;
- the raw read-back of clamped and reserved codes;
- that a write colliding with bus_cycle_done defers the switch to the next pulse.

// File: rtl/clkdiv_pkg.sv
// Package: shared widths and code helpers for the clock enable generator.
// Assumes ratio codes are log2 of the divide ratio, saturating at MAX_CODE.
package clkdiv_pkg;
    localparam int CODE_W   = 3;
    localparam int MAX_CODE = 4;
    localparam int CNT_W    = MAX_CODE;
    localparam int REG_W    = 2 * CODE_W;

    typedef logic [CODE_W-1:0] code_t;

    // Map reserved codes onto the slowest legal ratio.
    function automatic code_t norm_code(input code_t c);
        return (c > code_t'(MAX_CODE)) ? code_t'(MAX_CODE) : c;
    endfunction
endpackage

// File: rtl/clkdiv_regs.sv
// Module: programmed-ratio register and pending tracker.
// Holds the raw codes as written. It raises pending on a write and asserts
// apply for the cycle in which a pending change meets bus completion with
// no write in flight. A colliding write takes precedence and keeps pending.
module clkdiv_regs
    import clkdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             bus_cycle_done,
    output code_t            prog_sys,
    output code_t            prog_per,
    output logic             pending,
    output logic             apply
);
    // Switch request: pending change, bus idle and no new write this cycle.
    always_comb apply = pending && bus_cycle_done && !wr_en;

    // Store written codes and track whether they still await the switch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_sys <= '0;
            prog_per <= '0;
            pending  <= 1'b0;
        end else begin
            if (wr_en) begin
                prog_sys <= wr_data[CODE_W-1:0];
                prog_per <= wr_data[REG_W-1:CODE_W];
                pending  <= 1'b1;
            end else if (apply) begin
                pending  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/clkdiv_clamp.sv
// Module: ratio normaliser and clamp (combinational).
// Folds reserved codes to MAX_CODE. It then makes the peripheral code no
// smaller than the core code, so the peripheral never runs faster.
module clkdiv_clamp
    import clkdiv_pkg::*;
(
    input  code_t raw_sys,
    input  code_t raw_per,
    output code_t lim_sys,
    output code_t lim_per
);
    code_t n_sys, n_per;

    // Normalise, then let the core ratio take priority.
    always_comb begin
        n_sys   = norm_code(raw_sys);
        n_per   = norm_code(raw_per);
        lim_sys = n_sys;
        lim_per = (n_per < n_sys) ? n_sys : n_per;
    end
endmodule

// File: rtl/clkdiv_counter.sv
// Module: power-of-two clock enable divider.
// The enable is high when the count is zero and the count wraps at
// 2**shift - 1. A restart forces the count to zero, so the next cycle
// starts a full period. Assumes shift <= CNT_W.
module clkdiv_counter #(
    parameter int CODE_W = 3,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [CODE_W-1:0] shift,
    output logic              ce
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] term;

    // Terminal count is the low 'shift' bits all set.
    always_comb term = ~({CNT_W{1'b1}} << shift);

    // Enable on count zero.
    always_comb ce = (cnt == '0);

    // Advance, wrap at terminal count, or realign on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) cnt <= '0;
        else if (cnt == term)  cnt <= '0;
        else                   cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/clkdiv_ctrl.sv
// Module: top of the dual ratio clock enable generator.
// Programmed ratios are deferred until bus completion. The clamped
// ratios are then latched into the active set, and both dividers
// restart on the same edge. Assumes bus_cycle_done is a one-cycle pulse
// synchronous to clk.
module clkdiv_ctrl
    import clkdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             bus_cycle_done,
    output logic [REG_W-1:0] rd_data,
    output logic             sys_ce,
    output logic             per_ce,
    output code_t            eff_sys,
    output code_t            eff_per,
    output logic             pending
);
    localparam int N_DOM = 2;

    code_t prog_sys, prog_per, lim_sys, lim_per;
    logic  apply;
    code_t act_code [N_DOM];
    logic  ce_vec   [N_DOM];

    clkdiv_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .bus_cycle_done(bus_cycle_done), .prog_sys(prog_sys),
        .prog_per(prog_per), .pending(pending), .apply(apply)
    );

    clkdiv_clamp u_clamp (
        .raw_sys(prog_sys), .raw_per(prog_per),
        .lim_sys(lim_sys), .lim_per(lim_per)
    );

    // Latch the clamped ratios into the active set on a switch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_code[0] <= '0;
            act_code[1] <= '0;
        end else if (apply) begin
            act_code[0] <= lim_sys;
            act_code[1] <= lim_per;
        end
    end

    // One divider per clock domain, all restarted together.
    for (genvar d = 0; d < N_DOM; d++) begin : g_div
        clkdiv_counter #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_div (
            .clk(clk), .rst_n(rst_n), .restart(apply),
            .shift(act_code[d]), .ce(ce_vec[d])
        );
    end

    // Drive the outputs: read-back, enables and status.
    always_comb begin
        rd_data = {prog_per, prog_sys};
        sys_ce  = ce_vec[0];
        per_ce  = ce_vec[1];
        eff_sys = act_code[0];
        eff_per = act_code[1];
    end
endmodule

// File: rtl/clkdiv_ctrl_chk.sv
// Module: property checker for clkdiv_ctrl, attached with bind.
// Observes only the top-level ports.
module clkdiv_ctrl_chk
    import clkdiv_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             bus_cycle_done,
    input logic             sys_ce,
    input logic             per_ce,
    input code_t            eff_sys,
    input code_t            eff_per,
    input logic             pending
);
    // R7
    per_not_faster_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eff_per >= eff_sys);

    // R6
    eff_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_sys <= code_t'(MAX_CODE)) && (eff_per <= code_t'(MAX_CODE)));

    // R3
    pending_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> pending);

    // R3
    hold_while_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pending && bus_cycle_done && !wr_en) |=> $stable(eff_sys) && $stable(eff_per));

    // R4
    pending_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && bus_cycle_done && !wr_en) |=> !pending);

    // R8
    restart_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && bus_cycle_done && !wr_en) |=> (sys_ce && per_ce));

    // R9
    per_within_sys_chk: assert property (@(posedge clk) disable iff (!rst_n)
        per_ce |-> sys_ce);
endmodule

bind clkdiv_ctrl clkdiv_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .bus_cycle_done(bus_cycle_done),
    .sys_ce(sys_ce), .per_ce(per_ce), .eff_sys(eff_sys), .eff_per(eff_per),
    .pending(pending)
);

// File: tb/tb_clkdiv_ctrl.sv
// Directed bench for clkdiv_ctrl. Inputs change on the falling edge and
// outputs are sampled on the falling edge.
module tb_clkdiv_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [5:0] wr_data = '0;
    logic       bus_cycle_done = 1'b0;
    logic [5:0] rd_data;
    logic       sys_ce, per_ce, pending;
    logic [2:0] eff_sys, eff_per;

    int checks = 0;
    int failures = 0;

    clkdiv_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .bus_cycle_done(bus_cycle_done), .rd_data(rd_data), .sys_ce(sys_ce),
        .per_ce(per_ce), .eff_sys(eff_sys), .eff_per(eff_per), .pending(pending)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Writes: {per, sys}. Ends at the falling edge after the write edge.
    task automatic do_write(input int s, input int p);
        wr_en = 1'b1;
        wr_data = {3'(p), 3'(s)};
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_done();
        bus_cycle_done = 1'b1;
        @(negedge clk);
        bus_cycle_done = 1'b0;
    endtask

    // Cycles until the selected enable is next high.
    task automatic next_ce(input bit per, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!(per ? per_ce : sys_ce) && n < 64);
    endtask

    // After a switch: check both enables, then measure both periods.
    task automatic check_periods(input string req, input int ps, input int pp);
        int n;
        check("R8", {req, " sys_ce after switch"}, int'(sys_ce), 1);
        check("R8", {req, " per_ce after switch"}, int'(per_ce), 1);
        next_ce(1'b0, n);
        check(req, "sys period", n, ps);
        next_ce(1'b0, n);
        check(req, "sys period repeat", n, ps);
        next_ce(1'b1, n);
        check(req, "per period", n, pp);
    endtask

    task automatic t_reset();
        check("R1", "rd_data", int'(rd_data), 0);
        check("R1", "eff_sys", int'(eff_sys), 0);
        check("R1", "eff_per", int'(eff_per), 0);
        check("R1", "pending", int'(pending), 0);
        for (int i = 0; i < 4; i++) begin
            check("R1", "sys_ce each cycle", int'(sys_ce), 1);
            check("R1", "per_ce each cycle", int'(per_ce), 1);
            @(negedge clk);
        end
    endtask

    task automatic t_defer_and_apply();
        do_write(1, 2);
        check("R2", "rd_data layout", int'(rd_data), 6'b010_001);
        check("R3", "pending set", int'(pending), 1);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R3", "eff_sys held", int'(eff_sys), 0);
            check("R3", "sys_ce still every cycle", int'(sys_ce), 1);
            check("R3", "per_ce still every cycle", int'(per_ce), 1);
        end
        do_done();
        check("R4", "eff_sys applied", int'(eff_sys), 1);
        check("R4", "eff_per applied", int'(eff_per), 2);
        check("R4", "pending cleared", int'(pending), 0);
        check_periods("R6", 2, 4);
    endtask

    task automatic t_idle_done();
        do_done();
        check("R4", "idle done eff_sys", int'(eff_sys), 1);
        check("R4", "idle done eff_per", int'(eff_per), 2);
        check("R4", "idle done pending", int'(pending), 0);
    endtask

    task automatic t_clamp();
        do_write(3, 1);
        do_done();
        check("R7", "eff_sys", int'(eff_sys), 3);
        check("R7", "eff_per clamped", int'(eff_per), 3);
        check("R2", "rd_data raw per", int'(rd_data), 6'b001_011);
        check_periods("R7", 8, 8);
    endtask

    task automatic t_reserved();
        do_write(6, 7);
        do_done();
        check("R6", "reserved eff_sys", int'(eff_sys), 4);
        check("R6", "reserved eff_per", int'(eff_per), 4);
        check("R2", "rd_data reserved raw", int'(rd_data), 6'b111_110);
        check_periods("R6", 16, 16);
    endtask

    task automatic t_collide();
        do_write(0, 0);
        wr_en = 1'b1;
        wr_data = {3'd3, 3'd2};
        bus_cycle_done = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        bus_cycle_done = 1'b0;
        check("R5", "pending kept", int'(pending), 1);
        check("R5", "eff_sys unchanged", int'(eff_sys), 4);
        check("R5", "latest stored", int'(rd_data), 6'b011_010);
        do_done();
        check("R5", "later apply eff_sys", int'(eff_sys), 2);
        check("R5", "later apply eff_per", int'(eff_per), 3);
        check_periods("R8", 4, 8);
    endtask

    task automatic t_align();
        int bad = 0;
        do_write(1, 4);
        do_done();
        for (int i = 0; i < 64; i++) begin
            if (per_ce && !sys_ce) bad++;
            @(negedge clk);
        end
        check("R9", "per_ce without sys_ce count", bad, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_defer_and_apply();
        t_idle_done();
        t_clamp();
        t_reserved();
        t_collide();
        t_align();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule